// File: doc/BRIEF.md
# Pattern Page Mapper with Nametable Select

This block sits between the picture processor's pattern-table address bus and the external character memory. It translates any address in the 8 KB pattern space into the number of a 1 KB page in that memory. It also drives the single select line that picks one of two nametable memories for the current nametable access.

Each of eight character banks is 16 bits wide. The CPU loads a bank one byte at a time, through separate low-byte and high-byte registers. A 2-bit granularity code, shared with the rest of the system, chooses how those banks are used. The pattern space is split into 8 KB, 4 KB, 2 KB or 1 KB windows, and all four granularities draw on the same bank registers.

The nametable layout is set in one of two ways. A basic 2-bit field gives vertical, horizontal, single-lower or single-upper. An extended mode instead derives the layout from one bit held in each of four quadrant registers. Page number and select bit follow the address combinationally. A register write takes effect from the clock edge that accepts it.

Top module: `tile_page_mapper`

## Requirements
- R1: After reset all sixteen bank bytes are zero and the layout is vertical with extended mode off. In granularity 3 every slot then gives page 0, and nametable select equals address bit 10.
- R2: A write to 0x9000+i loads the low byte of bank i, and a write to 0xA000+i loads the high byte of bank i (i = address bits 2:0). The bank value is high*256 + low.
- R3: Granularity 0 (8 KB): the page for slot s (s = address bits 12:10) is bank0*8 + s.
- R4: Granularity 1 (4 KB): slots 0 to 3 give bank0*4 + s, and slots 4 to 7 give bank4*4 + (s-4).
- R5: Granularity 2 (2 KB): slot s gives bank(2*floor(s/2))*2 + (s mod 2).
- R6: Granularity 3 (1 KB): slot s gives bank s. A change of the granularity input takes effect in the same cycle, with no register write needed.
- R7: A write to 0xD001 with data bit 3 clear selects the basic layout from data bits 1:0. Code 0 is vertical (select = address bit 10), 1 is horizontal (select = address bit 11), 2 is select held 0, and 3 is select held 1.
- R8: With data bit 3 of the 0xD001 write set, the layout comes from bit 0 of the quadrant registers written at 0xB000 to 0xB003. Read in register order 0,1,2,3: all zeros gives select 0, all ones gives select 1, 0,1,0,1 gives vertical, and 0,0,1,1 or any other pattern gives horizontal.
- R9: Clearing bit 3 again returns to the basic layout, and the quadrant registers keep their contents for later use.
- R10: Writes outside the decoded registers change neither page nor select. This covers address pages other than 0x9, 0xA, 0xB and 0xD, indices 4 to 7 on page 0xB, and any index other than 1 on page 0xD.
- R11: Address bits 11:3 are not decoded, so for example 0x97F8 loads the low byte of bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| chrMode | input | 2 | Granularity code from the shared control register |
| ppuAddr | input | 14 | Picture processor address |
| chrPage | output | 16 | 1 KB character page number |
| ntSel | output | 1 | Nametable memory select |

## Verification
Two things can land in the same cycle: a bank register write and a change of the granularity input. Both feed the page path. The bench applies both together and checks the page twice. It first checks during that cycle, when it must combine the new granularity with the old bank bytes. It checks again after the edge, when it must carry the new byte. Constrained random writes across decoded, mirrored and undecoded addresses are mixed with directed sweeps of every slot, granularity and quadrant pattern. Each result is compared with a model written from the requirements.

// File: rtl/tpm_pkg.sv
`timescale 1ns/1ps
package tpm_pkg;
  localparam int REG_W = 8;
  localparam int IDX_W = 3;
  localparam int NT_QUADS = 4;
  localparam int QUAD_IDX_W = $clog2(NT_QUADS);
  localparam int MIR_EXT_BIT = 3;
  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] PAGE_LO   = 4'h9;
  localparam logic [NIB_W-1:0] PAGE_HI   = 4'hA;
  localparam logic [NIB_W-1:0] PAGE_QUAD = 4'hB;
  localparam logic [NIB_W-1:0] PAGE_CTRL = 4'hD;
  localparam logic [IDX_W-1:0] MIRROR_IDX = 3'd1;

  typedef enum logic [1:0] {
    LAYOUT_VERT = 2'd0,
    LAYOUT_HORZ = 2'd1,
    LAYOUT_LOW  = 2'd2,
    LAYOUT_HIGH = 2'd3
  } ntLayout_e;

  typedef struct packed {
    logic             loWr;
    logic             hiWr;
    logic             quadWr;
    logic             mirWr;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/tpm_ctrl.sv
`timescale 1ns/1ps
module tpm_ctrl
  import tpm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output regStrobe_t        stb
);
  logic [NIB_W-1:0] pageNib;
  logic [IDX_W-1:0] idx;

  assign pageNib = wrAddr[ADDR_W-1 -: NIB_W];
  assign idx     = wrAddr[IDX_W-1:0];

  always_comb begin
    stb        = '0;
    stb.idx    = idx;
    stb.data   = wrData;
    stb.loWr   = wrEn && (pageNib == PAGE_LO);
    stb.hiWr   = wrEn && (pageNib == PAGE_HI);
    stb.quadWr = wrEn && (pageNib == PAGE_QUAD) && (int'(idx) < NT_QUADS);
    stb.mirWr  = wrEn && (pageNib == PAGE_CTRL) && (idx == MIRROR_IDX);
  end
endmodule

// File: rtl/tpm_bankpath.sv
`timescale 1ns/1ps
module tpm_bankpath
  import tpm_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int PAGE_SHIFT = 10,
  parameter int PPU_AW     = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           stb,
  input  logic [1:0]           chrMode,
  input  logic [PPU_AW-1:0]    ppuAddr,
  output logic [2*REG_W-1:0]   chrPage
);
  localparam int SLOT_W = $clog2(BANKS);
  localparam int PAGE_W = 2 * REG_W;

  logic [REG_W-1:0] loQ [BANKS];
  logic [REG_W-1:0] hiQ [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ[g] <= '0;
        hiQ[g] <= '0;
      end else begin
        if (stb.loWr && stb.idx == IDX_W'(g)) loQ[g] <= stb.data;
        if (stb.hiWr && stb.idx == IDX_W'(g)) hiQ[g] <= stb.data;
      end
    end
  end

  logic [SLOT_W-1:0] slot;
  logic [1:0]        shiftAmt;
  logic [SLOT_W-1:0] lowMask;
  logic [SLOT_W-1:0] selBank;
  logic [PAGE_W-1:0] bankVal;

  always_comb begin
    slot     = ppuAddr[PAGE_SHIFT +: SLOT_W];
    shiftAmt = ~chrMode;
    lowMask  = ~({SLOT_W{1'b1}} << shiftAmt);
    selBank  = slot & ~lowMask;
    bankVal  = {hiQ[selBank], loQ[selBank]};
    chrPage  = (bankVal << shiftAmt) | PAGE_W'(slot & lowMask);
  end
endmodule

// File: rtl/tpm_ntpath.sv
`timescale 1ns/1ps
module tpm_ntpath
  import tpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t stb,
  input  logic [1:0] quadSel,
  output logic       ntSel
);
  logic [NT_QUADS-1:0] quadQ;
  logic [1:0]          mirQ;
  logic                extQ;
  ntLayout_e           layout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quadQ <= '0;
      mirQ  <= 2'd0;
      extQ  <= 1'b0;
    end else begin
      if (stb.quadWr) quadQ[stb.idx[QUAD_IDX_W-1:0]] <= stb.data[0];
      if (stb.mirWr) begin
        mirQ <= stb.data[1:0];
        extQ <= stb.data[MIR_EXT_BIT];
      end
    end
  end

  always_comb begin
    if (extQ) begin
      case ({quadQ[0], quadQ[1], quadQ[2], quadQ[3]})
        4'b0000: layout = LAYOUT_LOW;
        4'b1111: layout = LAYOUT_HIGH;
        4'b0101: layout = LAYOUT_VERT;
        default: layout = LAYOUT_HORZ;
      endcase
    end else begin
      layout = ntLayout_e'(mirQ);
    end
    case (layout)
      LAYOUT_VERT: ntSel = quadSel[0];
      LAYOUT_HORZ: ntSel = quadSel[1];
      LAYOUT_LOW:  ntSel = 1'b0;
      default:     ntSel = 1'b1;
    endcase
  end
endmodule

// File: rtl/tile_page_mapper.sv
`timescale 1ns/1ps
module tile_page_mapper
  import tpm_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int ADDR_W     = 16,
  parameter int PPU_AW     = 14,
  parameter int PAGE_SHIFT = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [REG_W-1:0]    wrData,
  input  logic [1:0]          chrMode,
  input  logic [PPU_AW-1:0]   ppuAddr,
  output logic [2*REG_W-1:0]  chrPage,
  output logic                ntSel
);
  regStrobe_t stb;

  tpm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb)
  );

  tpm_bankpath #(
    .BANKS      (BANKS),
    .PAGE_SHIFT (PAGE_SHIFT),
    .PPU_AW     (PPU_AW)
  ) u_bank (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .chrMode (chrMode),
    .ppuAddr (ppuAddr),
    .chrPage (chrPage)
  );

  tpm_ntpath u_nt (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .quadSel (ppuAddr[PAGE_SHIFT +: 2]),
    .ntSel   (ntSel)
  );
endmodule

// File: rtl/tpm_checker.sv
`timescale 1ns/1ps
module tpm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrAddr,
  input logic [7:0]  wrData,
  input logic [1:0]  chrMode,
  input logic [13:0] ppuAddr,
  input logic [15:0] chrPage,
  input logic        ntSel
);
  // R2
  lo_byte_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[15:12] == 4'h9 && chrMode == 2'd3 && ppuAddr[12:10] == wrAddr[2:0])
    |=> (!$stable(chrMode) || !$stable(ppuAddr[12:10]) || chrPage[7:0] == $past(wrData)));

  // R3
  gran8_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chrMode == 2'd0) |-> (chrPage[2:0] == ppuAddr[12:10]));

  // R4
  gran4_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chrMode == 2'd1) |-> (chrPage[1:0] == ppuAddr[11:10]));

  // R5
  gran2_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chrMode == 2'd2) |-> (chrPage[0] == ppuAddr[10]));

  // R7
  single_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 16'hD001 && !wrData[3] && wrData[1:0] == 2'd2) |=> !ntSel);

  // R7
  single_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 16'hD001 && !wrData[3] && wrData[1:0] == 2'd3) |=> ntSel);

  // R10
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[15:12] != 4'h9 && wrAddr[15:12] != 4'hA &&
     wrAddr[15:12] != 4'hB && wrAddr[15:12] != 4'hD)
    |=> (!$stable(chrMode) || !$stable(ppuAddr) || ($stable(chrPage) && $stable(ntSel))));
endmodule

bind tile_page_mapper tpm_checker u_chk (.*);

// File: tb/tb_tile_page_mapper.sv
`timescale 1ns/1ps
module tb_tile_page_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  chrMode = 2'd3;
  logic [13:0] ppuAddr = '0;
  logic [15:0] chrPage;
  logic        ntSel;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  logic [7:0] mLo [8];
  logic [7:0] mHi [8];
  logic       mQ  [4];
  logic [1:0] mMir;
  logic       mExt;

  always #5 clk = ~clk;

  tile_page_mapper dut (.*);

  function automatic logic [15:0] bankOf(input int b);
    return {mHi[b], mLo[b]};
  endfunction

  function automatic logic [15:0] expPage(input int mode, input int s);
    logic [15:0] r;
    case (mode)
      0: r = (bankOf(0) << 3) + 16'(s);
      1: r = (s < 4) ? (bankOf(0) << 2) + 16'(s) : (bankOf(4) << 2) + 16'(s - 4);
      2: r = (bankOf((s / 2) * 2) << 1) + 16'(s % 2);
      default: r = bankOf(s);
    endcase
    return r;
  endfunction

  function automatic logic expNt(input int q);
    int lay;
    if (mExt) begin
      if (!mQ[0] && !mQ[1] && !mQ[2] && !mQ[3]) lay = 2;
      else if (mQ[0] && mQ[1] && mQ[2] && mQ[3]) lay = 3;
      else if (!mQ[0] && mQ[1] && !mQ[2] && mQ[3]) lay = 0;
      else lay = 1;
    end else lay = int'(mMir);
    case (lay)
      0: return q[0];
      1: return q[1];
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic void modelWrite(input logic [15:0] a, input logic [7:0] d);
    int i;
    i = int'(a[2:0]);
    case (a[15:12])
      4'h9: mLo[i] = d;
      4'hA: mHi[i] = d;
      4'hB: if (i < 4) mQ[i] = d[0];
      4'hD: if (i == 1) begin mMir = d[1:0]; mExt = d[3]; end
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic sweepPages(input string tag);
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        chrMode = 2'(m);
        ppuAddr = {1'b0, 3'(s), 10'($urandom % 1024)};
        #1;
        chk(tag, chrPage, expPage(m, s));
      end
    end
  endtask

  task automatic sweepNt(input string tag);
    for (int q = 0; q < 4; q++) begin
      ppuAddr = 14'h2000 | 14'(q << 10) | 14'($urandom % 1024);
      #1;
      chk(tag, 16'(ntSel), 16'(expNt(q)));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 8; i++) begin mLo[i] = '0; mHi[i] = '0; end
    for (int i = 0; i < 4; i++) mQ[i] = 1'b0;
    mMir = 2'd0; mExt = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 8; s++) begin
      chrMode = 2'd3; ppuAddr = {1'b0, 3'(s), 10'h0}; #1;
      chk("R1 page", chrPage, 16'h0000);
    end
    ppuAddr = 14'h2400; #1; chk("R1 nt vert q1", 16'(ntSel), 16'h1);
    ppuAddr = 14'h2800; #1; chk("R1 nt vert q2", 16'(ntSel), 16'h0);

    // R2 byte assembly, R6 direct 1 KB
    doWrite(16'h9005, 8'h34);
    doWrite(16'hA005, 8'h12);
    chrMode = 2'd3; ppuAddr = 14'h1400; #1;
    chk("R2 bank5", chrPage, 16'h1234);

    // R11 undecoded middle address bits
    doWrite(16'h97F8, 8'hC3);
    chrMode = 2'd3; ppuAddr = 14'h0000; #1;
    chk("R11 mirror lo", chrPage, 16'h00C3);
    doWrite(16'hAFF8, 8'h01);
    #1; chk("R11 mirror hi", chrPage, 16'h01C3);

    // fill all banks with distinct values, then sweep all granularities
    for (int b = 0; b < 8; b++) begin
      doWrite(16'h9000 | 16'(b), 8'(8'h10 * b + 3));
      doWrite(16'hA000 | 16'(b), 8'(8'h21 + b));
    end
    sweepPages("R3 R4 R5 R6 sweep");
    doWrite(16'hA000, 8'hFF);
    chrMode = 2'd0; ppuAddr = 14'h1C00; #1;
    chk("R3 truncation", chrPage, expPage(0, 7));

    // R6 same-cycle: write plus granularity change
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'h9000; wrData = 8'h5E;
    chrMode = 2'd0; ppuAddr = 14'h0C00;
    #1; chk("R6 same cycle old byte", chrPage, expPage(0, 3));
    @(negedge clk);
    wrEn = 1'b0; modelWrite(16'h9000, 8'h5E);
    #1; chk("R6 after edge new byte", chrPage, expPage(0, 3));
    chrMode = 2'd2; #1; chk("R6 mode switch", chrPage, expPage(2, 3));

    // R7 basic layouts
    for (int l = 0; l < 4; l++) begin
      doWrite(16'hD001, 8'(l) | 8'hF4 & 8'hF7);
      sweepNt("R7 basic layout");
    end

    // R8 extended patterns
    doWrite(16'hD001, 8'h08);
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 4; q++) doWrite(16'hB000 | 16'(q), 8'(((p >> q) & 1) | 8'h06));
      sweepNt("R8 extended");
    end
    doWrite(16'hB000, 8'h0); doWrite(16'hB001, 8'h1);
    doWrite(16'hB002, 8'h0); doWrite(16'hB003, 8'h1);
    sweepNt("R8 vertical pattern");

    // R9 back to basic, then extended again with kept quadrants
    doWrite(16'hD001, 8'h01);
    sweepNt("R9 basic again");
    doWrite(16'hD001, 8'h08);
    sweepNt("R9 quadrants kept");

    // R10 ignored writes
    doWrite(16'hB004, 8'hFF); doWrite(16'hB007, 8'hFF);
    doWrite(16'hD000, 8'h0B); doWrite(16'hD003, 8'h0B);
    doWrite(16'h8000, 8'hEE); doWrite(16'hC001, 8'hEE);
    doWrite(16'hE003, 8'hEE); doWrite(16'h5800, 8'hEE);
    sweepPages("R10 pages unchanged");
    sweepNt("R10 nt unchanged");

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [15:0] a;
      int kind;
      kind = int'($urandom % 6);
      a = 16'($urandom);
      case (kind)
        0: a[15:12] = 4'h9;
        1: a[15:12] = 4'hA;
        2: a[15:12] = 4'hB;
        3: a[15:12] = 4'hD;
        4: a = 16'hD001;
        default: ;
      endcase
      doWrite(a, 8'($urandom));
      chrMode = 2'($urandom % 4);
      ppuAddr = 14'($urandom);
      #1;
      chk("R2 R11 random page", chrPage, expPage(int'(chrMode), int'(ppuAddr[12:10])));
      chk("R7 R8 R10 random nt", 16'(ntSel), 16'(expNt(int'(ppuAddr[11:10]))));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule